// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter with a serial output. It watches three host pins: an active-low chip-select, an active-low output-enable and a serial clock. From them it runs one conversion cycle, which has an acquire phase, a hold point and eight bit-decision steps. The result leaves the block one bit at a time on a single data line, most significant bit first. The host shifts data on the falling edges of the serial clock and samples it on the rising edges.

The analog comparator is not modelled. Two parallel 8-bit sample words stand in for the comparator decisions of two input sources. The sample word is an offset-binary code, with 0 at the negative end of the range and 255 at the positive end. A channel pin picks one of the two sources. A mode pin picks one of two output codings:
- unipolar: the sample word is passed through unchanged;
- bipolar: the word is turned into two's complement by inverting its top bit.

Both selections are latched once per cycle. All pins are brought into the system clock domain through two-flop synchronisers. Pin edges are found on the synchronised levels. A one-cycle completion pulse marks the end of each conversion.

Top module: `sar_serial_seq`

## Requirements
- R1: A falling edge on `cs_n_i` starts a conversion cycle only if `oe_n_i` is low at that moment and no conversion is in progress. A falling edge while `oe_n_i` is high starts nothing, and `done_o` stays low.
- R2: The selected sample word is captured on the 3rd serial clock falling edge of the cycle. Changes to the sample inputs before that edge are taken into the result. Changes after it have no effect on the result.
- R3: `dout_o` stays 0 through serial clock falling edges 1 to 3. The result's bit 7 appears on `dout_o` after falling edge 4.
- R4: After falling edges 4 to 11, `dout_o` carries result bits 7 down to 0, one bit per edge. Bit 0 stays on the line until the next serial clock falling edge, after which `dout_o` returns to 0 and the block is idle. `dout_o` is 0 out of reset.
- R5: The mode pin `uni_i` and the channel pin `chan_i` are latched at the first serial clock rising edge after the starting chip-select edge. Channel 0 selects `sample_a_i` and channel 1 selects `sample_b_i`. Later changes to these pins have no effect on the current cycle.
- R6: With the mode pin at 1 (unipolar), the result equals the selected sample word.
- R7: With the mode pin at 0 (bipolar), the result is the selected sample word with bit 7 inverted. For example, 0x80 gives 0x00, 0xFF gives 0x7F and 0x00 gives 0x80.
- R8: Raising `cs_n_i` during a conversion does not stop it. The remaining bits are still shifted out correctly.
- R9: A `cs_n_i` falling edge during a conversion is ignored, and the edge count continues. The first falling edge after falling edge 11 starts a new cycle, even while bit 0 is still on the line.
- R10: `done_o` is 1 for exactly one system clock per conversion. It rises on the same system clock edge on which bit 0 appears on `dout_o`.
- R11: While `oe_n_i` is high, `dout_o` is 0, but the conversion keeps counting edges. When `oe_n_i` goes low again, the current bit shows on the line again, and `done_o` still pulses.
- R12: A pin change that is set up before system clock edge k shows its effect on `dout_o` or `done_o` at edge k+2: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip-select pin, active low |
| oe_n_i | input | 1 | Output-enable pin, active low |
| sclk_i | input | 1 | Serial clock pin from the host |
| uni_i | input | 1 | Mode pin: 1 unipolar, 0 bipolar |
| chan_i | input | 1 | Channel pin: 0 selects sample A, 1 selects sample B |
| sample_a_i | input | 8 | Offset-binary sample word of source A |
| sample_b_i | input | 8 | Offset-binary sample word of source B |
| dout_o | output | 1 | Serial result, MSB first |
| done_o | output | 1 | One-clock pulse when the conversion completes |

## Verification
Every pin event reaches the outputs on the third system clock edge after it is driven, because of two synchroniser flops and the output register. The bench drives pins between clock edges. It then waits five system clocks before it samples `dout_o` or `done_o` on a falling clock edge, so each result is read well after it settles and before the next pin event. For the exact latency, the bench reads the line two edges after a serial clock fall, when it must still hold the old value. It reads again one edge later, when the new bit must be there. It uses the same pair of reads to find the single cycle in which `done_o` is high together with bit 0.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Phase of one conversion cycle
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a start
        ST_CONV = 2'd1,   // counting serial clock falls, shifting bits
        ST_TAIL = 2'd2    // complete; LSB still on the line
    } seq_state_e;

endpackage

// File: rtl/sar_pin_sync.sv
// Multi-bit level synchroniser: each pin passes through STAGES flops.
// STAGES must be 2 or more.
module sar_pin_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o
);

    logic [STAGES-1:0] pipe_d [W];
    logic [STAGES-1:0] pipe_q [W];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            pipe_d[i] = {pipe_q[i][STAGES-2:0], pin_i[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < W; i++) begin
                pipe_q[i] <= {STAGES{RST_VAL[i]}};
            end
        end else begin
            for (int i = 0; i < W; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_level
        assign level_o[g] = pipe_q[g][STAGES-1];
    end

endmodule

// File: rtl/sar_edge_pulse.sv
// One-cycle pulse on a chosen transition of a synchronised level.
module sar_edge_pulse #(
    parameter bit   RISING   = 1'b0,
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_VAL;
        else        prev_q <= prev_d;
    end

    if (RISING) begin : g_rise
        assign pulse_o = level_i & ~prev_q;
    end else begin : g_fall
        assign pulse_o = ~level_i & prev_q;
    end

endmodule

// File: rtl/sar_sample_path.sv
// Configuration latch, channel select, mode coding and result shifter.
module sar_sample_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb_i,
    input  logic              mode_lvl_i,
    input  logic              chan_lvl_i,
    input  logic              hold_stb_i,
    input  logic              shift_stb_i,
    input  logic [DATA_W-1:0] sample_a_i,
    input  logic [DATA_W-1:0] sample_b_i,
    output logic              msb_o
);

    localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic              mode;
        logic              chan;
        logic [DATA_W-1:0] word;
    } path_s;

    path_s path_d, path_q;
    logic [DATA_W-1:0] picked;

    always_comb begin
        path_d = path_q;
        picked = path_q.chan ? sample_b_i : sample_a_i;
        if (cfg_stb_i) begin
            path_d.mode = mode_lvl_i;
            path_d.chan = chan_lvl_i;
        end
        if (hold_stb_i) begin
            path_d.word = path_q.mode ? picked : (picked ^ SIGN_FLIP);
        end else if (shift_stb_i) begin
            path_d.word = {path_q.word[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) path_q <= '0;
        else        path_q <= path_d;
    end

    assign msb_o = path_q.word[DATA_W-1];

    // R2
    word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_stb_i && !shift_stb_i) |=> $stable(path_q.word));

    // R5
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_stb_i |=> ($stable(path_q.mode) && $stable(path_q.chan)));

endmodule

// File: rtl/sar_conv_ctrl.sv
// Conversion phase sequencer: edge counting, strobes, output bit and done.
module sar_conv_ctrl
    import sar_seq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HOLD_EDGE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall_i,
    input  logic oe_n_lvl_i,
    input  logic sclk_rise_i,
    input  logic sclk_fall_i,
    input  logic msb_i,
    output logic cfg_stb_o,
    output logic hold_stb_o,
    output logic shift_stb_o,
    output logic dout_o,
    output logic done_o
);

    localparam int MSB_EDGE  = HOLD_EDGE + 1;
    localparam int LAST_EDGE = HOLD_EDGE + DATA_W;
    localparam int CNT_W     = $clog2(LAST_EDGE + 1);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_EDGE);
    localparam logic [CNT_W-1:0] MSB_C  = CNT_W'(MSB_EDGE);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_EDGE);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             cfg_wait;
        logic             drive;
        logic             bit_v;
        logic             dout;
        logic             done;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  start;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        cfg_stb_o   = 1'b0;
        hold_stb_o  = 1'b0;
        shift_stb_o = 1'b0;
        start       = cs_fall_i && !oe_n_lvl_i && (ctrl_q.state != ST_CONV);

        if (start) begin
            ctrl_d.state    = ST_CONV;
            ctrl_d.cnt      = '0;
            ctrl_d.cfg_wait = 1'b1;
            ctrl_d.drive    = 1'b0;
            ctrl_d.bit_v    = 1'b0;
        end else begin
            unique case (ctrl_q.state)
                ST_CONV: begin
                    if (sclk_rise_i && ctrl_q.cfg_wait) begin
                        cfg_stb_o       = 1'b1;
                        ctrl_d.cfg_wait = 1'b0;
                    end
                    if (sclk_fall_i) begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                        if (ctrl_d.cnt == HOLD_C) begin
                            hold_stb_o = 1'b1;
                        end
                        if (ctrl_d.cnt >= MSB_C) begin
                            ctrl_d.drive = 1'b1;
                            ctrl_d.bit_v = msb_i;
                            shift_stb_o  = 1'b1;
                        end
                        if (ctrl_d.cnt == LAST_C) begin
                            ctrl_d.done  = 1'b1;
                            ctrl_d.state = ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (sclk_fall_i) begin
                        ctrl_d.state = ST_IDLE;
                        ctrl_d.drive = 1'b0;
                        ctrl_d.bit_v = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        ctrl_d.dout = ctrl_d.drive && ctrl_d.bit_v && !oe_n_lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.state <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign dout_o = ctrl_q.dout;
    assign done_o = ctrl_q.done;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |=> !ctrl_q.done);

    // R10
    done_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |-> (ctrl_q.state == ST_TAIL));

    // R11
    oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_lvl_i |=> !ctrl_q.dout);

    // R4
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE) |-> !ctrl_q.dout);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_CONV && !sclk_fall_i) |=> (ctrl_q.cnt == $past(ctrl_q.cnt)));

endmodule

// File: rtl/sar_serial_seq.sv
// Top: pin synchronisation, edge detection, sequencer and sample path.
module sar_serial_seq #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_EDGE   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              sclk_i,
    input  logic              uni_i,
    input  logic              chan_i,
    input  logic [DATA_W-1:0] sample_a_i,
    input  logic [DATA_W-1:0] sample_b_i,
    output logic              dout_o,
    output logic              done_o
);

    // Pin vector order: 0 cs_n, 1 oe_n, 2 sclk, 3 mode, 4 channel
    localparam int               PIN_W    = 5;
    localparam logic [PIN_W-1:0] PIN_IDLE = 5'b00011;

    logic [PIN_W-1:0] pin_lvl;
    logic cs_fall, sclk_rise, sclk_fall;
    logic cfg_stb, hold_stb, shift_stb, msb;

    sar_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   ({chan_i, uni_i, sclk_i, oe_n_i, cs_n_i}),
        .level_o (pin_lvl)
    );

    sar_edge_pulse #(.RISING(1'b0), .IDLE_VAL(PIN_IDLE[0])) u_cs_fall (
        .clk (clk), .rst_n (rst_n), .level_i (pin_lvl[0]), .pulse_o (cs_fall)
    );

    sar_edge_pulse #(.RISING(1'b1), .IDLE_VAL(PIN_IDLE[2])) u_sclk_rise (
        .clk (clk), .rst_n (rst_n), .level_i (pin_lvl[2]), .pulse_o (sclk_rise)
    );

    sar_edge_pulse #(.RISING(1'b0), .IDLE_VAL(PIN_IDLE[2])) u_sclk_fall (
        .clk (clk), .rst_n (rst_n), .level_i (pin_lvl[2]), .pulse_o (sclk_fall)
    );

    sar_conv_ctrl #(
        .DATA_W    (DATA_W),
        .HOLD_EDGE (HOLD_EDGE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (cs_fall),
        .oe_n_lvl_i  (pin_lvl[1]),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .msb_i       (msb),
        .cfg_stb_o   (cfg_stb),
        .hold_stb_o  (hold_stb),
        .shift_stb_o (shift_stb),
        .dout_o      (dout_o),
        .done_o      (done_o)
    );

    sar_sample_path #(
        .DATA_W (DATA_W)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_stb_i   (cfg_stb),
        .mode_lvl_i  (pin_lvl[3]),
        .chan_lvl_i  (pin_lvl[4]),
        .hold_stb_i  (hold_stb),
        .shift_stb_i (shift_stb),
        .sample_a_i  (sample_a_i),
        .sample_b_i  (sample_b_i),
        .msb_o       (msb)
    );

endmodule

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;

    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, oe_n = 1'b0, sclk = 1'b0, uni = 1'b1, chan = 1'b0;
    logic [7:0] smp_a = 8'h00, smp_b = 8'h00;
    logic dout, done;

    int checks = 0, fails = 0, pulses = 0, long_pulses = 0;
    logic done_prev = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sar_serial_seq u_dut (
        .clk (clk), .rst_n (rst_n), .cs_n_i (cs_n), .oe_n_i (oe_n),
        .sclk_i (sclk), .uni_i (uni), .chan_i (chan),
        .sample_a_i (smp_a), .sample_b_i (smp_b),
        .dout_o (dout), .done_o (done)
    );

    always @(posedge clk) begin
        if (done && !done_prev) pulses++;
        if (done && done_prev) long_pulses++;
        done_prev <= done;
    end

    function automatic logic [7:0] exp_code(input logic [7:0] a, b, input logic m, c);
        logic [7:0] s;
        s = c ? b : a;
        return m ? s : (s ^ 8'h80);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cs(input logic v);
        cs_n = v; wait_n(HALF);
    endtask

    task automatic rise();
        sclk = 1'b1; wait_n(HALF);
    endtask

    task automatic fall();
        sclk = 1'b0; wait_n(HALF);
    endtask

    // Serial clock pulses first..last of a cycle; records bits after falls 4..11
    task automatic clocks(input int first, input int last, inout logic [7:0] w);
        for (int k = first; k <= last; k++) begin
            rise(); fall();
            if (k < 4) chk(dout == 1'b0, "R3 dout before MSB", dout, 0);
            else if (k <= 11) w[11-k] = dout;
        end
    endtask

    task automatic t_reset();
        chk(dout == 1'b0, "R4 reset dout", dout, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
    endtask

    task automatic t_basic(input logic [7:0] a, b, input logic m, c, input string req);
        logic [7:0] w = 8'h00, e;
        int p0;
        smp_a = a; smp_b = b; uni = m; chan = c;
        e = exp_code(a, b, m, c);
        p0 = pulses;
        set_cs(1'b0);
        clocks(1, 11, w);
        chk(w == e, req, w, e);
        chk(pulses - p0 == 1 && long_pulses == 0, "R10 one pulse", pulses - p0, 1);
        set_cs(1'b1);
        chk(dout == e[0], "R4 LSB held", dout, e[0]);
        rise(); fall();
        chk(dout == 1'b0, "R4 idle after tail", dout, 0);
    endtask

    task automatic t_hold();
        logic [7:0] w = 8'h00;
        smp_a = 8'h11; uni = 1'b1; chan = 1'b0;
        set_cs(1'b0);
        clocks(1, 2, w);
        smp_a = 8'h5A;
        clocks(3, 3, w);
        smp_a = 8'hC3;
        clocks(4, 11, w);
        chk(w == 8'h5A, "R2 captured at fall 3", w, 8'h5A);
        set_cs(1'b1); rise(); fall();
    endtask

    task automatic t_cfg();
        logic [7:0] w = 8'h00;
        smp_a = 8'h3C; smp_b = 8'hE1; uni = 1'b1; chan = 1'b0;
        set_cs(1'b0);
        rise();
        uni = 1'b0; chan = 1'b1;
        fall();
        clocks(2, 11, w);
        chk(w == 8'h3C, "R5 cfg latched at first rise", w, 8'h3C);
        set_cs(1'b1); rise(); fall();
    endtask

    task automatic t_cs_ignore();
        logic [7:0] w = 8'h00, e;
        int p0;
        smp_a = 8'h96; smp_b = 8'h2D; uni = 1'b1; chan = 1'b0;
        p0 = pulses;
        set_cs(1'b0);
        clocks(1, 2, w);
        set_cs(1'b1);
        clocks(3, 5, w);
        set_cs(1'b0);
        clocks(6, 11, w);
        chk(w == 8'h96, "R8 R9 cs activity ignored", w, 8'h96);
        chk(pulses - p0 == 1, "R9 completion count", pulses - p0, 1);
        // restart from the tail phase, LSB still on the line
        set_cs(1'b1);
        uni = 1'b0; chan = 1'b1;
        e = exp_code(smp_a, smp_b, 1'b0, 1'b1);
        set_cs(1'b0);
        w = 8'h00;
        clocks(1, 11, w);
        chk(w == e, "R9 restart after completion", w, e);
        set_cs(1'b1); rise(); fall();
    endtask

    task automatic t_oe_start();
        logic [7:0] w = 8'h00;
        int p0;
        p0 = pulses;
        oe_n = 1'b1;
        set_cs(1'b0);
        oe_n = 1'b0;
        wait_n(HALF);
        clocks(1, 11, w);
        chk(pulses - p0 == 0, "R1 no start with oe high", pulses - p0, 0);
        chk(w == 8'h00, "R1 line quiet", w, 0);
        set_cs(1'b1); rise(); fall();
    endtask

    task automatic t_oe_mask();
        logic [7:0] w = 8'h00;
        int p0;
        smp_b = 8'hFF; uni = 1'b1; chan = 1'b1;
        p0 = pulses;
        set_cs(1'b0);
        clocks(1, 5, w);
        oe_n = 1'b1; wait_n(HALF);
        chk(dout == 1'b0, "R11 masked", dout, 0);
        clocks(6, 7, w);
        chk(w[5:4] == 2'b00, "R11 masked bits", w[5:4], 0);
        oe_n = 1'b0; wait_n(HALF);
        chk(dout == 1'b1, "R11 restored", dout, 1);
        clocks(8, 11, w);
        chk(w[3:0] == 4'hF && pulses - p0 == 1, "R11 conversion continued", w[3:0], 4'hF);
        set_cs(1'b1); rise(); fall();
    endtask

    task automatic t_latency();
        logic [7:0] w = 8'h00;
        smp_a = 8'h81; uni = 1'b1; chan = 1'b0;
        set_cs(1'b0);
        clocks(1, 3, w);
        rise();
        sclk = 1'b0;
        wait_n(2);
        chk(dout == 1'b0, "R12 two edges after fall", dout, 0);
        wait_n(1);
        chk(dout == 1'b1, "R12 third edge MSB", dout, 1);
        wait_n(HALF - 3);
        clocks(5, 10, w);
        rise();
        sclk = 1'b0;
        wait_n(2);
        chk(done == 1'b0, "R10 done not early", done, 0);
        wait_n(1);
        chk(done == 1'b1 && dout == 1'b1, "R10 done with LSB", {done, dout}, 3);
        wait_n(1);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        wait_n(HALF - 4);
        set_cs(1'b1); rise(); fall();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_basic(8'hA5, 8'h00, 1'b1, 1'b0, "R6 unipolar chA");
        t_basic(8'h00, 8'h3C, 1'b0, 1'b1, "R7 bipolar chB");
        t_basic(8'h80, 8'h11, 1'b0, 1'b0, "R7 bipolar mid-scale");
        t_basic(8'h22, 8'hFF, 1'b1, 1'b1, "R6 unipolar full scale");
        t_basic(8'hFF, 8'h00, 1'b0, 1'b0, "R7 bipolar top");
        t_hold();
        t_cfg();
        t_cs_ignore();
        t_oe_start();
        t_oe_mask();
        t_latency();
        finished = 1'b1;
        report();
        $finish;
    end

endmodule